// File: doc/BRIEF.md
# SCSI Command Buffer Loader

This block fills a small fixed-size command buffer for a SCSI-style controller. Command bytes reach the buffer by one of two routes. Software can write them one at a time through a FIFO register port. A DMA fetch can also pull a whole command from an external byte memory. The length of that fetch comes from a 24-bit transfer count, built from three byte-wide register values.

Both routes are bounded by the buffer size. A FIFO write that would land past the last entry is dropped and raises a sticky overrun flag. A DMA count larger than the buffer makes the fetch give up at once with a zero length, and no memory request is made. A fetch that returns a nonzero length switches the block into command mode and hands the command on with a one-cycle valid pulse. Downstream logic then reads the bytes through a read port and frees the block with an acknowledge strobe.

Outside command mode, FIFO writes fill the buffer as plain data. The data count may not reach the last entry: a write that arrives while the count is one below the buffer size is an overrun.

Top module: `cmd_buf_loader`

## Requirements
- R1: After reset, the command length, data count, command mode, overrun flag, command valid and fetch done outputs are all zero.
- R2: In command mode, a FIFO write stores bits [7:0] of the written value at buffer index equal to the command length, then the command length increments by one.
- R3: In command mode, a FIFO write while the command length equals DEPTH (16) stores nothing, leaves the length at 16 and sets the overrun flag.
- R4: Outside command mode, a FIFO write stores bits [7:0] at index equal to the data count and increments the count. When the count equals DEPTH-1 (15), the write is dropped and the overrun flag is set.
- R5: The transfer count is tc_lo | tc_mid<<8 | tc_hi<<16. If it is 0 or greater than DEPTH, no memory request is made. In that case fetch_done pulses in the cycle after the start with fetch_len 0, no command valid follows, and command mode and length are unchanged.
- R6: For a transfer count n in 1..DEPTH, the block reads memory addresses 0..n-1, one byte per cycle in which mem_valid is high. Each byte is stored at the buffer index equal to its address. fetch_done then pulses with fetch_len equal to n.
- R7: One cycle after a fetch_done with nonzero length, cmd_valid pulses, command mode is 1 and the command length equals the fetched length.
- R8: The overrun flag stays set until an err_clr strobe. An overrun in the same cycle as err_clr leaves the flag set.
- R9: cmd_ack clears command mode, the command length and the data count. A FIFO write in the same cycle as cmd_ack has no effect.
- R10: While a fetch is in progress (fetch_busy high), FIFO writes and new start strobes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fifo_wr_i | input | 1 | FIFO register write strobe |
| fifo_val_i | input | WR_W | Written value; only the low byte is used |
| tc_lo_i | input | 8 | Transfer count, bits 7:0 |
| tc_mid_i | input | 8 | Transfer count, bits 15:8 |
| tc_hi_i | input | 8 | Transfer count, bits 23:16 |
| dma_start_i | input | 1 | Start a command fetch |
| mem_req_o | output | 1 | Byte read request to memory |
| mem_addr_o | output | IDX_W | Byte offset being requested |
| mem_valid_i | input | 1 | Memory byte valid, one beat per cycle |
| mem_data_i | input | 8 | Memory byte |
| cmd_ack_i | input | 1 | Downstream consumed the command |
| err_clr_i | input | 1 | Clears the overrun flag |
| rd_idx_i | input | IDX_W | Buffer read index |
| rd_data_o | output | 8 | Buffer byte at rd_idx_i |
| cmd_valid_o | output | 1 | One-cycle pulse: command handed on |
| cmd_len_o | output | LEN_W | Command length |
| data_cnt_o | output | LEN_W | Data byte count outside command mode |
| cmd_mode_o | output | 1 | Command mode active |
| ovr_err_o | output | 1 | Sticky overrun flag |
| fetch_busy_o | output | 1 | Fetch in progress |
| fetch_done_o | output | 1 | One-cycle pulse: fetch finished |
| fetch_len_o | output | LEN_W | Length returned by the last fetch |

## Verification
The bench builds the block with its defaults: DEPTH 16, WR_W 32, and a 24-bit count from three bytes. A 16-entry buffer lets a few dozen FIFO writes drive both the command-length and data-count bounds into overrun many times. The 24-bit count lets the bench use values whose low byte is small but whose middle or high byte is nonzero. Those values must be rejected, which exposes any count that is assembled from too few bytes. Random memory stalls vary the spacing between fetch beats.

// File: rtl/cmd_buf_pkg.sv
package cmd_buf_pkg;
  localparam int unsigned TC_W = 24;
  typedef enum logic {F_IDLE, F_RUN} fetch_st_e;
endpackage

// File: rtl/cmd_buf_store.sv
module cmd_buf_store #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] widx_i,
  input  logic [7:0]       wdata_i,
  input  logic [IDX_W-1:0] ridx_i,
  output logic [7:0]       rdata_o
);
  logic [7:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem_q[g] <= '0;
      else if (we_i && widx_i == IDX_W'(g)) mem_q[g] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[ridx_i];
endmodule

// File: rtl/cmd_buf_fetch.sv
module cmd_buf_fetch
  import cmd_buf_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned IDX_W = $clog2(DEPTH),
  localparam int unsigned LEN_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [TC_W-1:0]  tcount_i,
  output logic             mem_req_o,
  output logic [IDX_W-1:0] mem_addr_o,
  input  logic             mem_valid_i,
  input  logic [7:0]       mem_data_i,
  output logic             wr_en_o,
  output logic [IDX_W-1:0] wr_idx_o,
  output logic [7:0]       wr_data_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [LEN_W-1:0] len_o
);
  fetch_st_e        st_q;
  logic [IDX_W-1:0] cnt_q;
  logic [LEN_W-1:0] tgt_q, len_q;
  logic             done_q;
  logic             bad_len;

  assign bad_len = (tcount_i == '0) || (tcount_i > TC_W'(DEPTH));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= F_IDLE;
      cnt_q  <= '0;
      tgt_q  <= '0;
      len_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        F_IDLE: if (start_i) begin
          if (bad_len) begin
            // oversized or empty count: give up without touching memory
            done_q <= 1'b1;
            len_q  <= '0;
          end else begin
            st_q  <= F_RUN;
            cnt_q <= '0;
            tgt_q <= LEN_W'(tcount_i);
          end
        end
        F_RUN: if (mem_valid_i) begin
          cnt_q <= cnt_q + 1'b1;
          if (LEN_W'(cnt_q) + 1'b1 == tgt_q) begin
            st_q   <= F_IDLE;
            done_q <= 1'b1;
            len_q  <= tgt_q;
          end
        end
        default: st_q <= F_IDLE;
      endcase
    end
  end

  assign mem_req_o  = (st_q == F_RUN);
  assign mem_addr_o = cnt_q;
  assign wr_en_o    = (st_q == F_RUN) && mem_valid_i;
  assign wr_idx_o   = cnt_q;
  assign wr_data_o  = mem_data_i;
  assign busy_o     = (st_q == F_RUN);
  assign done_o     = done_q;
  assign len_o      = len_q;

  p_reject_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == F_IDLE && start_i && tcount_i > TC_W'(DEPTH)) |=> (done_o && len_o == '0 && !mem_req_o));
  p_beat_in_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_valid_i) |-> (LEN_W'(mem_addr_o) < tgt_q));
  p_done_len_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (len_o <= LEN_W'(DEPTH)));
endmodule

// File: rtl/cmd_buf_loader.sv
module cmd_buf_loader
  import cmd_buf_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned WR_W  = 32,
  localparam int unsigned IDX_W = $clog2(DEPTH),
  localparam int unsigned LEN_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fifo_wr_i,
  input  logic [WR_W-1:0]  fifo_val_i,
  input  logic [7:0]       tc_lo_i,
  input  logic [7:0]       tc_mid_i,
  input  logic [7:0]       tc_hi_i,
  input  logic             dma_start_i,
  output logic             mem_req_o,
  output logic [IDX_W-1:0] mem_addr_o,
  input  logic             mem_valid_i,
  input  logic [7:0]       mem_data_i,
  input  logic             cmd_ack_i,
  input  logic             err_clr_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [7:0]       rd_data_o,
  output logic             cmd_valid_o,
  output logic [LEN_W-1:0] cmd_len_o,
  output logic [LEN_W-1:0] data_cnt_o,
  output logic             cmd_mode_o,
  output logic             ovr_err_o,
  output logic             fetch_busy_o,
  output logic             fetch_done_o,
  output logic [LEN_W-1:0] fetch_len_o
);
  logic [LEN_W-1:0] len_q, dcnt_q;
  logic             mode_q, err_q, cvalid_q;

  logic             f_we, f_busy, f_done;
  logic [IDX_W-1:0] f_idx;
  logic [7:0]       f_data;
  logic [LEN_W-1:0] f_len;
  logic [TC_W-1:0]  tcount;

  assign tcount = {tc_hi_i, tc_mid_i, tc_lo_i};

  cmd_buf_fetch #(.DEPTH(DEPTH)) i_fetch (
    .clk_i, .rst_ni,
    .start_i    (dma_start_i),
    .tcount_i   (tcount),
    .mem_req_o,
    .mem_addr_o,
    .mem_valid_i,
    .mem_data_i,
    .wr_en_o    (f_we),
    .wr_idx_o   (f_idx),
    .wr_data_o  (f_data),
    .busy_o     (f_busy),
    .done_o     (f_done),
    .len_o      (f_len)
  );

  logic fifo_ok, cmd_wr, cmd_ovr, dat_wr, dat_ovr, cmd_full, dat_full, f_ok;
  assign fifo_ok  = fifo_wr_i && !f_busy && !cmd_ack_i;
  assign cmd_full = (len_q == LEN_W'(DEPTH));
  assign dat_full = (dcnt_q == LEN_W'(DEPTH - 1));
  assign cmd_wr   = fifo_ok &&  mode_q && !cmd_full;
  assign cmd_ovr  = fifo_ok &&  mode_q &&  cmd_full;
  assign dat_wr   = fifo_ok && !mode_q && !dat_full;
  assign dat_ovr  = fifo_ok && !mode_q &&  dat_full;
  assign f_ok     = f_done && (f_len != '0);

  logic             s_we;
  logic [IDX_W-1:0] s_idx;
  logic [7:0]       s_data;
  assign s_we   = f_we || cmd_wr || dat_wr;
  assign s_idx  = f_we ? f_idx : (mode_q ? IDX_W'(len_q) : IDX_W'(dcnt_q));
  assign s_data = f_we ? f_data : fifo_val_i[7:0];

  cmd_buf_store #(.DEPTH(DEPTH)) i_store (
    .clk_i, .rst_ni,
    .we_i    (s_we),
    .widx_i  (s_idx),
    .wdata_i (s_data),
    .ridx_i  (rd_idx_i),
    .rdata_o (rd_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q    <= '0;
      dcnt_q   <= '0;
      mode_q   <= 1'b0;
      err_q    <= 1'b0;
      cvalid_q <= 1'b0;
    end else begin
      err_q    <= (err_q && !err_clr_i) || cmd_ovr || dat_ovr;
      cvalid_q <= f_ok;
      if (f_ok) begin
        mode_q <= 1'b1;
        len_q  <= f_len;
      end else if (cmd_ack_i) begin
        mode_q <= 1'b0;
        len_q  <= '0;
      end else if (cmd_wr) begin
        len_q  <= len_q + 1'b1;
      end
      if (cmd_ack_i)   dcnt_q <= '0;
      else if (dat_wr) dcnt_q <= dcnt_q + 1'b1;
    end
  end

  assign cmd_valid_o  = cvalid_q;
  assign cmd_len_o    = len_q;
  assign data_cnt_o   = dcnt_q;
  assign cmd_mode_o   = mode_q;
  assign ovr_err_o    = err_q;
  assign fetch_busy_o = f_busy;
  assign fetch_done_o = f_done;
  assign fetch_len_o  = f_len;

  p_len_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_len_o <= LEN_W'(DEPTH));
  p_dcnt_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_cnt_o <= LEN_W'(DEPTH - 1));
  p_valid_mode_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> cmd_mode_o);
  p_err_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_err_o && !err_clr_i) |=> ovr_err_o);
  p_ack_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_ack_i && !fetch_done_o) |=> (cmd_len_o == '0 && data_cnt_o == '0 && !cmd_mode_o));
  p_busy_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_busy_o && !cmd_ack_i) |=> $stable(data_cnt_o));
endmodule

// File: tb/test_cmd_buf_loader.sv
`timescale 1ns/100ps
module test_cmd_buf_loader;
  localparam int DEPTH = 16;
  localparam int WR_W  = 32;
  localparam int IDX_W = $clog2(DEPTH);
  localparam int LEN_W = $clog2(DEPTH + 1);

  logic clk = 1'b0, rst_ni = 1'b0;
  logic fifo_wr_i = 0, dma_start_i = 0, mem_valid_i = 0, cmd_ack_i = 0, err_clr_i = 0;
  logic [WR_W-1:0] fifo_val_i = '0;
  logic [7:0] tc_lo_i = 0, tc_mid_i = 0, tc_hi_i = 0, mem_data_i = 0, rd_data_o;
  logic [IDX_W-1:0] rd_idx_i = '0, mem_addr_o;
  logic mem_req_o, cmd_valid_o, cmd_mode_o, ovr_err_o, fetch_busy_o, fetch_done_o;
  logic [LEN_W-1:0] cmd_len_o, data_cnt_o, fetch_len_o;

  always #5 clk = ~clk;

  cmd_buf_loader #(.DEPTH(DEPTH), .WR_W(WR_W)) i_cmd_buf_loader (.clk_i(clk), .*);

  int errs = 0, checks = 0;
  bit finished = 0;
  logic [7:0] mbuf [DEPTH];
  logic [7:0] img [DEPTH];
  int mlen = 0, mdcnt = 0;
  bit mmode = 0, merr = 0;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_state(string req);
    chk({req, " mode"}, cmd_mode_o, mmode);
    chk({req, " len"}, cmd_len_o, mlen);
    chk({req, " dcnt"}, data_cnt_o, mdcnt);
    chk({req, " err"}, ovr_err_o, merr);
  endtask

  task automatic chk_buf(string req);
    int bad = 0, first = -1;
    for (int i = 0; i < DEPTH; i++) begin
      rd_idx_i = IDX_W'(i);
      #0.2;
      if (rd_data_o !== mbuf[i]) begin
        bad++;
        if (first < 0) first = i;
      end
    end
    if (first < 0) first = 0;
    rd_idx_i = IDX_W'(first);
    #0.2;
    chk({req, " buffer byte"}, rd_data_o, mbuf[first]);
  endtask

  // model of one FIFO write; returns nothing, updates model
  task automatic model_wr(logic [WR_W-1:0] v);
    if (mmode) begin
      if (mlen < DEPTH) begin mbuf[mlen] = v[7:0]; mlen++; end
      else merr = 1;
    end else begin
      if (mdcnt != DEPTH - 1) begin mbuf[mdcnt] = v[7:0]; mdcnt++; end
      else merr = 1;
    end
  endtask

  task automatic fifo_wr(logic [WR_W-1:0] v, bit with_clr, string req);
    @(negedge clk);
    fifo_wr_i = 1; fifo_val_i = v; err_clr_i = with_clr;
    if (with_clr) merr = 0;
    model_wr(v);
    @(negedge clk);
    fifo_wr_i = 0; err_clr_i = 0;
    chk_state(req);
  endtask

  task automatic do_ack(bit with_wr);
    @(negedge clk);
    cmd_ack_i = 1; fifo_wr_i = with_wr; fifo_val_i = 32'hA5;
    mmode = 0; mlen = 0; mdcnt = 0;
    @(negedge clk);
    cmd_ack_i = 0; fifo_wr_i = 0;
    chk_state("R9 ack");
  endtask

  task automatic do_clr();
    @(negedge clk);
    err_clr_i = 1; merr = 0;
    @(negedge clk);
    err_clr_i = 0;
    chk("R8 clear", ovr_err_o, 0);
  endtask

  task automatic do_dma(logic [23:0] tc, bit wr_during);
    int n = int'(tc);
    @(negedge clk);
    {tc_hi_i, tc_mid_i, tc_lo_i} = tc; dma_start_i = 1;
    @(negedge clk);
    dma_start_i = 0;
    if (n == 0 || n > DEPTH) begin
      chk("R5 reject done", fetch_done_o, 1);
      chk("R5 reject len", fetch_len_o, 0);
      chk("R5 no request", mem_req_o, 0);
      @(negedge clk);
      chk("R5 no valid", cmd_valid_o, 0);
      chk_state("R5 unchanged");
    end else begin
      for (int i = 0; i < DEPTH; i++) img[i] = 8'($urandom);
      for (int k = 0; k < 2000; k++) begin
        if (fetch_done_o) break;
        mem_valid_i = mem_req_o && ($urandom % 4 != 0);
        mem_data_i  = img[mem_addr_o];
        fifo_wr_i   = wr_during && (k == 0);
        fifo_val_i  = 32'h5A;
        if (k == 1 && wr_during) begin
          chk("R10 busy", fetch_busy_o, 1);
        end
        dma_start_i = wr_during && (k == 1);
        @(negedge clk);
      end
      mem_valid_i = 0; fifo_wr_i = 0; dma_start_i = 0;
      chk("R6 done", fetch_done_o, 1);
      chk("R6 fetch len", fetch_len_o, n);
      for (int i = 0; i < n; i++) mbuf[i] = img[i];
      mmode = 1; mlen = n;
      @(negedge clk);
      chk("R7 valid", cmd_valid_o, 1);
      chk_state("R7/R10 after fetch");
      chk_buf("R6 contents");
      @(negedge clk);
      chk("R7 valid one cycle", cmd_valid_o, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errs++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd4242);
    for (int i = 0; i < DEPTH; i++) mbuf[i] = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    // R1 reset state
    chk_state("R1 reset");
    chk("R1 valid", cmd_valid_o, 0);
    chk("R1 done", fetch_done_o, 0);

    // R4 data path up to the limit
    for (int i = 0; i < DEPTH; i++) fifo_wr(32'h1234_5600 + i, 0, "R4 data write");
    chk_buf("R4 contents");
    // R8 sticky
    repeat (3) @(negedge clk);
    chk("R8 sticky", ovr_err_o, 1);
    do_clr();
    // R8 set wins over clear
    fifo_wr(32'h77, 1, "R8 set wins");
    do_clr();
    do_ack(1);

    // R5 rejections, incl. upper bytes set with small low byte
    do_dma(24'd17, 0);
    do_dma(24'h010005, 0);
    do_dma(24'h000305, 0);
    do_dma(24'd0, 0);
    // R6/R7 full fetch, then R3 overrun
    do_dma(24'd16, 0);
    fifo_wr(32'hDEAD_BE01, 0, "R3 overrun");
    chk_buf("R3 not stored");
    do_clr();
    do_ack(0);
    // R2 append after short fetch
    do_dma(24'd3, 0);
    for (int i = 0; i < 4; i++) fifo_wr(32'hCAFE_0010 + 32'(i) * 32'h0101_0101, 0, "R2 cmd write");
    chk_buf("R2 contents");
    // R10 writes and starts during a fetch ignored
    do_ack(0);
    do_dma(24'd9, 1);

    // random phase
    for (int it = 0; it < 400; it++) begin
      int op = $urandom % 10;
      if (op < 6) fifo_wr($urandom, 0, "R2/R3/R4 random write");
      else if (op == 6) do_ack(0);
      else if (op == 7) do_clr();
      else begin
        int sel = $urandom % 4;
        logic [23:0] tc;
        case (sel)
          0: tc = 24'($urandom % 17);
          1: tc = 24'(17 + $urandom % 40);
          2: tc = {8'($urandom % 255 + 1), 16'($urandom)};
          default: tc = 24'(1 + $urandom % DEPTH);
        endcase
        do_dma(tc, $urandom % 2);
      end
    end
    chk_buf("R2/R4/R6 final contents");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule